// File: doc/BRIEF.md
# Multi-source GPIO bank controller

The block arbitrates ownership of 24 general-purpose I/O pins, grouped as two ports of 12. Port 0 occupies bits [11:0] of every 24-bit vector and port 1 occupies bits [23:12]. Each pin carries its own 3-bit owner code. That code picks one of eight agents: four radio slot/channel controllers, two SPI engines, a processor register interface, or user logic. The pin's output enable and output level come from the agent that owns it.

For radio-owned pins the block keeps three 24-bit registers: mode, direction and output. Software changes them with a value and a mask, and only the masked bits are updated. In manual mode the pin drives the output register. In automatic mode it drives the level that its radio channel supplies. Pin input levels pass through a two-stage synchronizer and can always be read back, whoever owns the pin.

Top module: `gpio_owner_mux`

## Requirements
- R1: After reset, the mode, direction and output registers and the input readback all read 0. Every owner code is 0, so no pin is output-enabled and every pin drives 0.
- R2: A register write with `reg_we_i` high changes only the bits set in `reg_mask_i`, which take the value of `reg_val_i`. Bit updates are visible from the next cycle. The `reg_sel_i` codes are 0 for mode, 1 for direction and 2 for output.
- R3: For a pin with owner code 0 to 3 and mode bit 0, the output enable equals the direction bit and the output level equals the output-register bit. The channel part of the code has no effect.
- R4: For a pin with owner code 0 to 3 and mode bit 1, the output level is bit p of `radio_auto_i[c*24 +: 24]`, where c is the code and p is the pin. The output enable is still the direction bit.
- R5: Owner code 4 selects SPI engine 0 and code 5 selects SPI engine 1. The pin then takes bit p of `spi_oe_i`/`spi_do_i` at offset s*24, where s is the engine number.
- R6: Owner code 6 connects the pin to `cpu_oe_i`/`cpu_do_i`, and code 7 connects it to `usr_oe_i`/`usr_do_i`.
- R7: While a pin has owner code 4 to 7, its mode, direction and output register bits have no effect on that pin.
- R8: `rd_sel_i` = 3 returns the pin inputs delayed by exactly two clock edges, regardless of ownership. `rd_sel_i` codes 0 to 2 return the mode, direction and output registers.
- R9: An owner write sets only the owner code of pin `src_pin_i`. A pin index of 24 or more changes no owner code.
- R10: A register write with `reg_sel_i` = 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_we_i | input | 1 | Masked register write strobe |
| reg_sel_i | input | 2 | Register target: 0 mode, 1 direction, 2 output, 3 none |
| reg_val_i | input | 24 | Write value |
| reg_mask_i | input | 24 | Write mask, 1 = update bit |
| src_we_i | input | 1 | Owner code write strobe |
| src_pin_i | input | 5 | Pin whose owner code is written |
| src_code_i | input | 3 | New owner code |
| rd_sel_i | input | 2 | Readback select: 0 mode, 1 direction, 2 output, 3 inputs |
| rd_data_o | output | 24 | Readback data |
| radio_auto_i | input | 96 | Automatic-mode levels, 24 bits per radio channel |
| spi_oe_i | input | 48 | SPI output enables, 24 bits per engine |
| spi_do_i | input | 48 | SPI output levels, 24 bits per engine |
| cpu_oe_i | input | 24 | Processor output enables |
| cpu_do_i | input | 24 | Processor output levels |
| usr_oe_i | input | 24 | User logic output enables |
| usr_do_i | input | 24 | User logic output levels |
| pin_di_i | input | 24 | Pin input levels |
| pin_oe_o | output | 24 | Pin output enables |
| pin_do_o | output | 24 | Pin output levels |

## Verification
Manual mode is tried with all four radio codes while the automatic levels differ from the output register. A leak from the channel code shows up here. Automatic mode gives each radio channel a distinct pattern on its own group of pins, which exposes a wrong channel or bit index. It then clears the mode of port 1 only, to separate the two port halves. SPI, processor and user ownership use patterns that differ from the radio registers and from each other, and the registers are rewritten while those agents own the pins. Masked writes, out-of-range owner writes, the reserved register select and the two-edge input delay are each probed at their boundary.

// File: rtl/gpio_owner_mux.sv
module gpio_owner_mux #(
  parameter int PORTS  = 2,
  parameter int PORT_W = 12,
  localparam int N     = PORTS * PORT_W,
  localparam int IW    = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [N-1:0]     reg_val_i,
  input  logic [N-1:0]     reg_mask_i,
  input  logic             src_we_i,
  input  logic [IW-1:0]    src_pin_i,
  input  logic [2:0]       src_code_i,
  input  logic [1:0]       rd_sel_i,
  output logic [N-1:0]     rd_data_o,
  input  logic [4*N-1:0]   radio_auto_i,
  input  logic [2*N-1:0]   spi_oe_i,
  input  logic [2*N-1:0]   spi_do_i,
  input  logic [N-1:0]     cpu_oe_i,
  input  logic [N-1:0]     cpu_do_i,
  input  logic [N-1:0]     usr_oe_i,
  input  logic [N-1:0]     usr_do_i,
  input  logic [N-1:0]     pin_di_i,
  output logic [N-1:0]     pin_oe_o,
  output logic [N-1:0]     pin_do_o
);

  logic [N-1:0]        mode_q, dir_q, out_q, sync1_q, sync2_q;
  logic [N-1:0][2:0]   src_q;

  function automatic logic [N-1:0] merge(logic [N-1:0] cur, logic [N-1:0] val,
                                         logic [N-1:0] msk);
    return (cur & ~msk) | (val & msk);
  endfunction

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      dir_q   <= '0;
      out_q   <= '0;
      src_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_di_i;
      sync2_q <= sync1_q;
      if (reg_we_i) begin
        case (reg_sel_i)
          2'd0: mode_q <= merge(mode_q, reg_val_i, reg_mask_i);
          2'd1: dir_q  <= merge(dir_q,  reg_val_i, reg_mask_i);
          2'd2: out_q  <= merge(out_q,  reg_val_i, reg_mask_i);
          default: ;
        endcase
      end
      if (src_we_i && (int'(src_pin_i) < N))
        src_q[src_pin_i] <= src_code_i;
    end
  end

  always_comb begin
    case (rd_sel_i)
      2'd0:    rd_data_o = mode_q;
      2'd1:    rd_data_o = dir_q;
      2'd2:    rd_data_o = out_q;
      default: rd_data_o = sync2_q;
    endcase
  end

  for (genvar p = 0; p < N; p++) begin : g_pin
    logic [2:0] code;
    assign code = src_q[p];
    always_comb begin
      case (code)
        3'd4, 3'd5: begin
          pin_oe_o[p] = spi_oe_i[int'(code[0]) * N + p];
          pin_do_o[p] = spi_do_i[int'(code[0]) * N + p];
        end
        3'd6: begin
          pin_oe_o[p] = cpu_oe_i[p];
          pin_do_o[p] = cpu_do_i[p];
        end
        3'd7: begin
          pin_oe_o[p] = usr_oe_i[p];
          pin_do_o[p] = usr_do_i[p];
        end
        default: begin
          pin_oe_o[p] = dir_q[p];
          pin_do_o[p] = mode_q[p] ? radio_auto_i[int'(code[1:0]) * N + p] : out_q[p];
        end
      endcase
    end
  end

  logic [1:0] age_q;
  always_ff @(posedge clk_i) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pin_oe_o == '0 && pin_do_o == '0));

  a_r2_mask_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == 2'd1) |=>
      (((dir_q ^ $past(dir_q)) & ~$past(reg_mask_i)) == '0));

  a_r2_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == 2'd2) |=>
      ((out_q & $past(reg_mask_i)) == ($past(reg_val_i) & $past(reg_mask_i))));

  a_r8_sync_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (sync2_q == $past(pin_di_i, 2)));

  a_r9_src_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_we_i && int'(src_pin_i) >= N) |=> $stable(src_q));

  a_r10_reserved_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == 2'd3 && !src_we_i) |=>
      ($stable(mode_q) && $stable(dir_q) && $stable(out_q)));

endmodule

// File: tb/gpio_owner_mux_bench.sv
module gpio_owner_mux_bench;
  localparam int N = 24;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0, src_we = 0;
  logic [1:0] reg_sel = 0, rd_sel = 0;
  logic [N-1:0] reg_val = 0, reg_mask = 0, rd_data;
  logic [4:0] src_pin = 0;
  logic [2:0] src_code = 0;
  logic [4*N-1:0] radio_auto = 0;
  logic [2*N-1:0] spi_oe = 0, spi_do = 0;
  logic [N-1:0] cpu_oe = 0, cpu_do = 0, usr_oe = 0, usr_do = 0, pin_di = 0;
  logic [N-1:0] pin_oe, pin_do;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  gpio_owner_mux u_gpio_owner_mux (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_val_i(reg_val), .reg_mask_i(reg_mask), .src_we_i(src_we),
    .src_pin_i(src_pin), .src_code_i(src_code), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .radio_auto_i(radio_auto), .spi_oe_i(spi_oe),
    .spi_do_i(spi_do), .cpu_oe_i(cpu_oe), .cpu_do_i(cpu_do), .usr_oe_i(usr_oe),
    .usr_do_i(usr_do), .pin_di_i(pin_di), .pin_oe_o(pin_oe), .pin_do_o(pin_do));

  task automatic chk(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [N-1:0] val, logic [N-1:0] msk);
    reg_we = 1; reg_sel = sel; reg_val = val; reg_mask = msk;
    @(posedge clk); @(negedge clk);
    reg_we = 0;
  endtask

  task automatic own(int pin, logic [2:0] code);
    src_we = 1; src_pin = 5'(pin); src_code = code;
    @(posedge clk); @(negedge clk);
    src_we = 0;
  endtask

  task automatic rd(logic [1:0] sel, output logic [N-1:0] v);
    rd_sel = sel; #0.5; v = rd_data;
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v); chk("R1 readback zero", v, '0);
    end
    chk("R1 oe zero", pin_oe, '0);
    chk("R1 do zero", pin_do, '0);
  endtask

  task automatic t_mask();
    logic [N-1:0] v;
    wr(2'd1, 24'hFFFFFF, 24'h00F00F);
    rd(2'd1, v); chk("R2 masked set", v, 24'h00F00F);
    wr(2'd1, 24'h000000, 24'h000003);
    rd(2'd1, v); chk("R2 masked clear", v, 24'h00F00C);
    wr(2'd2, 24'h123456, 24'hFFF000);
    rd(2'd2, v); chk("R2 out upper only", v, 24'h123000);
  endtask

  task automatic t_manual();
    wr(2'd1, 24'hFFFFFF, 24'hFFFFFF);
    wr(2'd2, 24'hA5A5A5, 24'hFFFFFF);
    wr(2'd0, 24'h000000, 24'hFFFFFF);
    radio_auto = {4{24'h5A5A5A}};
    for (int p = 0; p < N; p++) own(p, 3'(p % 4));
    chk("R3 manual do", pin_do, 24'hA5A5A5);
    chk("R3 manual oe", pin_oe, 24'hFFFFFF);
    wr(2'd1, 24'h000000, 24'h0000FF);
    chk("R3 dir to input", pin_oe, 24'hFFFF00);
  endtask

  task automatic t_auto();
    logic [N-1:0] pat [4];
    logic [N-1:0] exp;
    pat[0] = 24'h0F0F0F; pat[1] = 24'h3C3C3C; pat[2] = 24'h555555; pat[3] = 24'hAAAAAA;
    radio_auto = {pat[3], pat[2], pat[1], pat[0]};
    for (int p = 0; p < N; p++) own(p, 3'(p / 6));
    wr(2'd0, 24'hFFFFFF, 24'hFFFFFF);
    exp = '0;
    for (int p = 0; p < N; p++) exp[p] = pat[p / 6][p];
    chk("R4 auto per channel", pin_do, exp);
    chk("R4 oe from dir", pin_oe, 24'hFFFF00);
    wr(2'd0, 24'h000000, 24'hFFF000);
    exp = {24'hA5A5A5 & 24'hFFF000} | (exp & 24'h000FFF);
    chk("R4 port1 manual port0 auto", pin_do, exp);
  endtask

  task automatic t_spi();
    spi_oe = {24'hF0F0F0, 24'h0FF00F};
    spi_do = {24'hCCCCCC, 24'h333333};
    for (int p = 0; p < N; p++) own(p, (p < 12) ? 3'd4 : 3'd5);
    chk("R5 spi oe", pin_oe, {12'hF0F, 12'h00F});
    chk("R5 spi do", pin_do, {12'hCCC, 12'h333});
    wr(2'd1, 24'h000000, 24'hFFFFFF);
    wr(2'd2, 24'hFFFFFF, 24'hFFFFFF);
    wr(2'd0, 24'hFFFFFF, 24'hFFFFFF);
    chk("R7 regs no effect oe", pin_oe, {12'hF0F, 12'h00F});
    chk("R7 regs no effect do", pin_do, {12'hCCC, 12'h333});
  endtask

  task automatic t_cpu_usr();
    logic [N-1:0] eo, ed;
    cpu_oe = 24'h00FFFF; cpu_do = 24'h123456;
    usr_oe = 24'hFFFF00; usr_do = 24'hFEDCBA;
    for (int p = 0; p < N; p++) own(p, (p % 2 == 0) ? 3'd6 : 3'd7);
    eo = (cpu_oe & 24'h555555) | (usr_oe & 24'hAAAAAA);
    ed = (cpu_do & 24'h555555) | (usr_do & 24'hAAAAAA);
    chk("R6 cpu/usr oe", pin_oe, eo);
    chk("R6 cpu/usr do", pin_do, ed);
    wr(2'd2, 24'h000000, 24'hFFFFFF);
    chk("R7 out reg ignored", pin_do, ed);
  endtask

  task automatic t_input();
    logic [N-1:0] v;
    pin_di = 24'h9ABCDE;
    @(posedge clk); @(negedge clk);
    rd(2'd3, v); chk("R8 one edge still old", v, 24'h000000);
    @(posedge clk); @(negedge clk);
    rd(2'd3, v); chk("R8 two edges new", v, 24'h9ABCDE);
  endtask

  task automatic t_guard();
    logic [N-1:0] od, oo, v, m, d, o;
    od = pin_do; oo = pin_oe;
    own(24, 3'd4); own(31, 3'd0);
    chk("R9 oob owner do", pin_do, od);
    chk("R9 oob owner oe", pin_oe, oo);
    own(5, 3'd4);
    od[5] = spi_do[5]; oo[5] = spi_oe[5];
    chk("R9 single pin owner do", pin_do, od);
    chk("R9 single pin owner oe", pin_oe, oo);
    rd(2'd0, m); rd(2'd1, d); rd(2'd2, o);
    wr(2'd3, 24'h5A5A5A, 24'hFFFFFF);
    rd(2'd0, v); chk("R10 mode kept", v, m);
    rd(2'd1, v); chk("R10 dir kept", v, d);
    rd(2'd2, v); chk("R10 out kept", v, o);
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_manual();
    t_auto();
    t_spi();
    t_cpu_usr();
    t_input();
    t_guard();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule